// File: doc/BRIEF.md
# Asynchronous Serial Channel with Routing Test Modes

This block is one full-duplex asynchronous serial channel. On the host side it has a simple parallel interface: a write strobe for outgoing characters, a read strobe for received ones, and a few level status outputs. On the line side it has one serial output and one serial input. Bit timing comes from an external `baudTick` pulse. The channel divides that pulse by sixteen in oversampled mode, or treats each pulse as one whole bit in 1x mode.

The transmitter has a holding register in front of its shift register. The host can therefore hand over the next character while the current one is still leaving the line. The receiver assembles one character in its shift register and keeps up to three finished characters in a first-word-fall-through queue. Each queued character carries its framing-error flag and its multidrop address flag. The stop period of transmitted characters can be stretched in sixteenth-of-a-bit steps. A two-bit routing field selects one of four paths:
- normal operation;
- echo of the line input onto the line output;
- an internal loop from transmitter to receiver;
- a remote loop that reflects the line without delivering data to the host.

Top module: `async_serial_port`

## Requirements
- R1: After reset, `txd` is high, `txReady` and `txEmpty` are 1, and `rxReady`, `rxFull` and `rxOverrun` are 0.
- R2: A transmitted character is sent as follows: a low start bit, 8 data bits least significant first, and, only when `cfgMultidrop`=1, a ninth bit equal to `txWrAddr`, then a high stop period. `txReady` is 1 while the holding register is empty. `txEmpty` is 1 only when the holding register is empty and the shift register is idle. A character written while the shift register is busy waits in the holding register.
- R3: With `cfgClk16`=1, every bit lasts 16 ticks and the stop period lasts 16+`cfgStop` ticks. A waiting character starts in the cycle after the last stop tick, so back-to-back frames repeat every 160+`cfgStop` ticks.
- R4: With `cfgClk16`=1, a low line seen on a tick is confirmed as a start bit only if it is still low 8 ticks later. Otherwise the receiver returns to idle and stores nothing. After confirmation, each later bit is sampled every 16 ticks.
- R5: With `cfgClk16`=0, every tick is one bit. The tick that first sees a low line is the start bit, and each following tick samples one bit.
- R6: Received characters are queued in a 3-entry first-word-fall-through queue. `rxRdData`/`rxRdAddr`/`rxRdFerr` show the oldest entry. `rxReady` means the queue is not empty, `rxFull` means it holds 3 entries, and a `rxRdEn` pulse removes the oldest entry.
- R7: A character that completes while the queue is full and no read is made in that cycle is discarded. It sets `rxOverrun`, which stays at 1 until an `ovrClr` pulse.
- R8: If a character completes in the same cycle that the host reads from a full queue, both take effect: the oldest entry leaves, the new one is stored, the queue stays full and `rxOverrun` stays 0.
- R9: If the stop bit is sampled low, the character is stored with `rxRdFerr`=1.
- R10: `cfgMode` selects the routing. 0: transmitter to `txd`, `rxd` to receiver. 1: `txd` follows `rxd` and the receiver still takes `rxd`. 2: transmitter feeds the receiver internally and `txd` is held high. 3: `txd` follows `rxd` and the receiver sees an idle line.
- R11: With `cfgMultidrop`=1, the receiver takes a ninth bit after the data and presents it as `rxRdAddr`. With `cfgMultidrop`=0, `rxRdAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle bit-clock pulse (16x or 1x of bit rate) |
| cfgMode | input | 2 | Routing select, encodings in R10 |
| cfgClk16 | input | 1 | 1: 16x oversampling, 0: one tick per bit |
| cfgStop | input | 4 | Extra stop length in sixteenths of a bit |
| cfgMultidrop | input | 1 | Enables the ninth address bit |
| txWrEn | input | 1 | Write strobe for the holding register |
| txWrData | input | 8 | Character to transmit |
| txWrAddr | input | 1 | Ninth bit to transmit in multidrop mode |
| txReady | output | 1 | Holding register empty |
| txEmpty | output | 1 | Holding and shift register both idle |
| rxRdEn | input | 1 | Removes the oldest received entry |
| rxRdData | output | 8 | Oldest received character |
| rxRdAddr | output | 1 | Address flag of the oldest entry |
| rxRdFerr | output | 1 | Framing-error flag of the oldest entry |
| rxReady | output | 1 | Queue not empty |
| rxFull | output | 1 | Queue holds three entries |
| rxOverrun | output | 1 | Sticky overrun flag |
| ovrClr | input | 1 | Clears `rxOverrun` |
| rxd | input | 1 | Serial line input |
| txd | output | 1 | Serial line output |

## Verification
The completion of a received character and a host read can both fall in the same clock cycle while the queue is full, and the outcome decides whether data is lost. The bench switches to 1x mode and drives every tick itself. This lets it raise the stop-bit tick of a fourth character in exactly the cycle that it pulses `rxRdEn`. It then checks three things: the read returned the oldest character, `rxOverrun` stayed clear, and the remaining queue drains in arrival order. A second collision, the end of a stop period coinciding with a waiting character in the holding register, is measured as the exact spacing between start bits.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    ROUTE_NORMAL = 2'd0,
    ROUTE_ECHO   = 2'd1,
    ROUTE_LOCAL  = 2'd2,
    ROUTE_REMOTE = 2'd3
  } routeMode_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rxState_t;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic txLoad;    // move holding register into the shift register
    logic txShift;   // advance the outgoing frame by one bit
    logic rxSample;  // capture the receive line into the shift register
    logic rxPush;    // stop bit sampled: store the character
  } chanStrobes_t;

endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 4,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              cfgClk16,
  input  logic              cfgMultidrop,
  input  logic [STOP_W-1:0] cfgStop,
  input  logic              holdValid,
  input  logic              rxIn,
  output chanStrobes_t      strb,
  output logic              txBusy
);

  localparam int CNT_W = $clog2(OVS + (1 << STOP_W));
  localparam int BIT_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] MID_LIM = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LIM = CNT_W'(OVS - 1);

  // ---------------- transmit sequencing ----------------
  logic             txActive;
  logic [CNT_W-1:0] txCnt;
  logic [BIT_W-1:0] txBit;
  logic [BIT_W-1:0] txLastIdx;
  logic             txLast;
  logic [CNT_W-1:0] txLim;
  logic             txEnd;

  always_comb begin
    txLastIdx = BIT_W'(DATA_W + 1) + BIT_W'(cfgMultidrop);
    txLast    = (txBit == txLastIdx);
    if (!cfgClk16)   txLim = '0;
    else if (txLast) txLim = BIT_LIM + CNT_W'(cfgStop);
    else             txLim = BIT_LIM;
    txEnd = txActive && baudTick && (txCnt == txLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txCnt    <= '0;
      txBit    <= '0;
    end else if (strb.txLoad) begin
      txActive <= 1'b1;
      txCnt    <= '0;
      txBit    <= '0;
    end else if (txEnd) begin
      txCnt <= '0;
      if (txLast) txActive <= 1'b0;
      else        txBit    <= txBit + 1'b1;
    end else if (txActive && baudTick) begin
      txCnt <= txCnt + 1'b1;
    end
  end

  // ---------------- receive sequencing ----------------
  rxState_t         rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [BIT_W-1:0] rxBit;
  logic [BIT_W-1:0] rxDataBits;
  logic [CNT_W-1:0] rxSampLim;
  logic             rxAtSample;

  always_comb begin
    rxDataBits = BIT_W'(DATA_W) + BIT_W'(cfgMultidrop);
    rxSampLim  = cfgClk16 ? BIT_LIM : '0;
    rxAtSample = (rxState == RX_DATA) && baudTick && (rxCnt == rxSampLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
    end else begin
      unique case (rxState)
        RX_IDLE: begin
          if (baudTick && !rxIn) begin
            rxCnt   <= '0;
            rxBit   <= '0;
            rxState <= cfgClk16 ? RX_START : RX_DATA;
          end
        end
        RX_START: begin
          if (baudTick) begin
            if (rxCnt == MID_LIM) begin
              rxCnt   <= '0;
              rxState <= rxIn ? RX_IDLE : RX_DATA;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (rxAtSample) begin
            rxCnt <= '0;
            if (rxBit == rxDataBits) rxState <= RX_IDLE;
            else                     rxBit   <= rxBit + 1'b1;
          end else if (baudTick) begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.txLoad   = holdValid && (!txActive || (txEnd && txLast));
    strb.txShift  = txEnd && !txLast;
    strb.rxSample = rxAtSample && (rxBit != rxDataBits);
    strb.rxPush   = rxAtSample && (rxBit == rxDataBits);
    txBusy        = txActive;
  end

endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RXQ_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobes_t      strb,
  input  routeMode_t        route,
  input  logic              cfgMultidrop,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txWrAddr,
  input  logic              rxRdEn,
  input  logic              ovrClr,
  input  logic              rxd,
  output logic              txd,
  output logic              holdValid,
  output logic              rxIn,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxRdAddr,
  output logic              rxRdFerr,
  output logic              rxReady,
  output logic              rxFull,
  output logic              rxOverrun
);

  localparam int SH_W  = DATA_W + 3;
  localparam int ENT_W = DATA_W + 2;
  localparam int PTR_W = (RXQ_DEPTH > 1) ? $clog2(RXQ_DEPTH) : 1;
  localparam int QC_W  = $clog2(RXQ_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(RXQ_DEPTH - 1);
  localparam logic [QC_W-1:0]  FULL_CNT = QC_W'(RXQ_DEPTH);

  // ---------------- transmit holding and shift ----------------
  logic [DATA_W-1:0] holdData;
  logic              holdAddr;
  logic [SH_W-1:0]   txSh;
  logic              txLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdAddr  <= 1'b0;
    end else if (strb.txLoad) begin
      holdValid <= 1'b0;
    end else if (txWrEn && !holdValid) begin
      holdValid <= 1'b1;
      holdData  <= txWrData;
      holdAddr  <= txWrAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '1;
    end else if (strb.txLoad) begin
      txSh <= cfgMultidrop ? {1'b1, holdAddr, holdData, 1'b0}
                           : {2'b11, holdData, 1'b0};
    end else if (strb.txShift) begin
      txSh <= {1'b1, txSh[SH_W-1:1]};
    end
  end

  assign txLine = txSh[0];

  // ---------------- line routing ----------------
  always_comb begin
    unique case (route)
      ROUTE_ECHO:   begin txd = rxd;    rxIn = rxd;    end
      ROUTE_LOCAL:  begin txd = 1'b1;   rxIn = txLine; end
      ROUTE_REMOTE: begin txd = rxd;    rxIn = 1'b1;   end
      default:      begin txd = txLine; rxIn = rxd;    end
    endcase
  end

  // ---------------- receive shift ----------------
  logic [DATA_W:0]  rxSh;
  logic [ENT_W-1:0] newEnt;

  always_ff @(posedge clk) begin
    if (!rstN)              rxSh <= '0;
    else if (strb.rxSample) rxSh <= {rxIn, rxSh[DATA_W:1]};
  end

  // entry layout: {framing error, address flag, data}
  always_comb begin
    if (cfgMultidrop) newEnt = {!rxIn, rxSh[DATA_W], rxSh[DATA_W-1:0]};
    else              newEnt = {!rxIn, 1'b0, rxSh[DATA_W:1]};
  end

  // ---------------- receive queue ----------------
  logic [ENT_W-1:0] qMem [RXQ_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [QC_W-1:0]  qCount;
  logic             doPop, doPush, dropChar;

  always_comb begin
    doPop    = rxRdEn && (qCount != '0);
    doPush   = strb.rxPush && ((qCount != FULL_CNT) || doPop);
    dropChar = strb.rxPush && !doPush;
  end

  for (genvar gi = 0; gi < RXQ_DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                                   qMem[gi] <= '0;
      else if (doPush && (wrPtr == PTR_W'(gi)))    qMem[gi] <= newEnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      qCount <= qCount + 1'b1;
      else if (doPop && !doPush) qCount <= qCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rxOverrun <= 1'b0;
    else if (dropChar) rxOverrun <= 1'b1;
    else if (ovrClr)   rxOverrun <= 1'b0;
  end

  always_comb begin
    {rxRdFerr, rxRdAddr, rxRdData} = qMem[rdPtr];
    rxReady = (qCount != '0);
    rxFull  = (qCount == FULL_CNT);
  end

endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RXQ_DEPTH = 3,
  parameter int STOP_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [1:0]        cfgMode,
  input  logic              cfgClk16,
  input  logic [STOP_W-1:0] cfgStop,
  input  logic              cfgMultidrop,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txWrAddr,
  output logic              txReady,
  output logic              txEmpty,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxRdAddr,
  output logic              rxRdFerr,
  output logic              rxReady,
  output logic              rxFull,
  output logic              rxOverrun,
  input  logic              ovrClr,
  input  logic              rxd,
  output logic              txd
);

  chanStrobes_t strb;
  logic         holdValid;
  logic         rxIn;
  logic         txBusy;

  asp_ctrl #(.DATA_W(DATA_W), .STOP_W(STOP_W), .OVS(16)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .baudTick     (baudTick),
    .cfgClk16     (cfgClk16),
    .cfgMultidrop (cfgMultidrop),
    .cfgStop      (cfgStop),
    .holdValid    (holdValid),
    .rxIn         (rxIn),
    .strb         (strb),
    .txBusy       (txBusy)
  );

  asp_datapath #(.DATA_W(DATA_W), .RXQ_DEPTH(RXQ_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .route        (routeMode_t'(cfgMode)),
    .cfgMultidrop (cfgMultidrop),
    .txWrEn       (txWrEn),
    .txWrData     (txWrData),
    .txWrAddr     (txWrAddr),
    .rxRdEn       (rxRdEn),
    .ovrClr       (ovrClr),
    .rxd          (rxd),
    .txd          (txd),
    .holdValid    (holdValid),
    .rxIn         (rxIn),
    .rxRdData     (rxRdData),
    .rxRdAddr     (rxRdAddr),
    .rxRdFerr     (rxRdFerr),
    .rxReady      (rxReady),
    .rxFull       (rxFull),
    .rxOverrun    (rxOverrun)
  );

  assign txReady = !holdValid;
  assign txEmpty = !holdValid && !txBusy;

endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cfgMode,
  input logic       rxd,
  input logic       txd,
  input logic       txWrEn,
  input logic       txReady,
  input logic       txEmpty,
  input logic       rxReady,
  input logic       rxFull,
  input logic       rxOverrun,
  input logic       ovrClr
);

  // R6: a full queue is never reported empty
  a_r6_full_has_data: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> rxReady);

  // R2: an idle channel always has a free holding register
  a_r2_empty_means_ready: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady);

  // R2: an accepted write occupies the holding register on the next cycle
  a_r2_write_occupies: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && txReady) |=> !txReady);

  // R10: internal loop keeps the line output idle
  a_r10_local_line_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd2) |-> txd);

  // R10: both reflecting modes copy the line input
  a_r10_reflect_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1 || cfgMode == 2'd3) |-> (txd == rxd));

  // R7: overrun is sticky until cleared
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !ovrClr) |=> rxOverrun);

  // R7: overrun can only appear while the queue was full
  a_r7_overrun_from_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxFull));

endmodule

bind async_serial_port asp_checker u_asp_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cfgMode   (cfgMode),
  .rxd       (rxd),
  .txd       (txd),
  .txWrEn    (txWrEn),
  .txReady   (txReady),
  .txEmpty   (txEmpty),
  .rxReady   (rxReady),
  .rxFull    (rxFull),
  .rxOverrun (rxOverrun),
  .ovrClr    (ovrClr)
);

// File: tb/async_serial_port_bench.sv
`timescale 1ns/1ps
module async_serial_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick;
  logic       autoTick = 1'b0;
  logic       tickAuto = 1'b1;
  logic       tickMan = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic       cfgClk16 = 1'b1;
  logic [3:0] cfgStop = 4'd0;
  logic       cfgMultidrop = 1'b0;
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic       txWrAddr = 1'b0;
  logic       txReady, txEmpty;
  logic       rdMon = 1'b0, rdMain = 1'b0;
  logic       rxRdEn;
  logic [7:0] rxRdData;
  logic       rxRdAddr, rxRdFerr, rxReady, rxFull, rxOverrun;
  logic       ovrClr = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;

  int total = 0;
  int bad = 0;
  logic monOn = 1'b0;
  logic [9:0] expQ [$];  // {ferr, addr, data}

  always #4 clk = ~clk;
  always @(negedge clk) autoTick <= ~autoTick;
  assign baudTick = tickAuto ? autoTick : tickMan;
  assign rxRdEn   = rdMon | rdMain;

  async_serial_port u_async_serial_port (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .cfgMode(cfgMode),
    .cfgClk16(cfgClk16), .cfgStop(cfgStop), .cfgMultidrop(cfgMultidrop),
    .txWrEn(txWrEn), .txWrData(txWrData), .txWrAddr(txWrAddr),
    .txReady(txReady), .txEmpty(txEmpty), .rxRdEn(rxRdEn),
    .rxRdData(rxRdData), .rxRdAddr(rxRdAddr), .rxRdFerr(rxRdFerr),
    .rxReady(rxReady), .rxFull(rxFull), .rxOverrun(rxOverrun),
    .ovrClr(ovrClr), .rxd(rxd), .txd(txd)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops the oldest expectation whenever the queue has data
  always @(negedge clk) begin
    rdMon <= 1'b0;
    if (monOn && rxReady && !rdMon) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected character", {rxRdFerr, rxRdAddr, rxRdData}, 0);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        check({rxRdFerr, rxRdAddr, rxRdData} == e, "R6/R9/R11 received entry",
              {rxRdFerr, rxRdAddr, rxRdData}, e);
      end
      rdMon <= 1'b1;
    end
  end

  task automatic waitTicks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (baudTick) k++;
    end
  endtask

  task automatic txWrite(input logic [7:0] d, input logic a);
    while (!txReady) @(negedge clk);
    txWrEn = 1'b1; txWrData = d; txWrAddr = a;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  // driver: expected item into scoreboard, character into transmitter
  task automatic sendLoop(input logic [7:0] d, input logic a);
    expQ.push_back({1'b0, a & cfgMultidrop, d});
    txWrite(d, a);
  endtask

  // bench-side serializer on rxd, 16x timing
  task automatic ser16(input logic [8:0] v, input logic md, input logic stopLvl);
    rxd = 1'b0; waitTicks(16);
    for (int i = 0; i < (md ? 9 : 8); i++) begin rxd = v[i]; waitTicks(16); end
    rxd = stopLvl; waitTicks(16);
    rxd = 1'b1; waitTicks(16);
  endtask

  task automatic tick1(input logic b, input logic rd);
    @(negedge clk);
    rxd = b; tickMan = 1'b1; rdMain = rd;
  endtask

  // bench-side serializer with hand-made ticks, 1x timing
  task automatic ser1x(input logic [7:0] v, input logic readAtStop);
    tick1(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) tick1(v[i], 1'b0);
    tick1(1'b1, readAtStop);
    @(negedge clk);
    tickMan = 1'b0; rdMain = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || rxReady) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(txd && txReady && txEmpty && !rxReady && !rxFull && !rxOverrun, "R1 reset state",
          {txd, txReady, txEmpty, rxReady, rxFull, rxOverrun}, 6'b111000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R10 local loop, 16x, several patterns through the scoreboard
    cfgMode = 2'd2; monOn = 1'b1;
    sendLoop(8'h55, 1'b0);
    @(negedge clk);
    check(txReady && !txEmpty, "R2 holding freed into shift", {txReady, txEmpty}, 2'b10);
    sendLoop(8'hA3, 1'b0);
    check(!txReady && !txEmpty, "R2 second char waits in holding", {txReady, txEmpty}, 2'b00);
    check(txd == 1'b1, "R10 local loop keeps txd high", txd, 1);
    sendLoop(8'h00, 1'b0);
    sendLoop(8'hFF, 1'b0);
    drain();
    check(expQ.size() == 0, "R10 local loop delivered all", expQ.size(), 0);
    while (!txEmpty) @(negedge clk);
    check(txEmpty && txReady, "R2 transmitter empty after frames", {txEmpty, txReady}, 2'b11);

    // R11 multidrop address flag
    cfgMultidrop = 1'b1;
    sendLoop(8'h41, 1'b1);
    sendLoop(8'h42, 1'b0);
    drain();
    check(expQ.size() == 0, "R11 multidrop frames delivered", expQ.size(), 0);
    while (!txEmpty) @(negedge clk);
    cfgMultidrop = 1'b0;

    // R5 one tick per bit, internal loop
    cfgClk16 = 1'b0;
    sendLoop(8'h3C, 1'b0);
    sendLoop(8'hC5, 1'b0);
    drain();
    check(expQ.size() == 0, "R5 1x loop delivered", expQ.size(), 0);
    while (!txEmpty) @(negedge clk);
    cfgClk16 = 1'b1;

    // R6/R7 fill queue then overrun
    monOn = 1'b0;
    sendLoop(8'h11, 1'b0);
    sendLoop(8'h22, 1'b0);
    sendLoop(8'h33, 1'b0);
    while (!txEmpty) @(negedge clk);
    repeat (8) @(negedge clk);
    check(rxFull && rxReady && !rxOverrun, "R6 three entries fill queue",
          {rxFull, rxReady, rxOverrun}, 3'b110);
    txWrite(8'h44, 1'b0);
    while (!txEmpty) @(negedge clk);
    repeat (8) @(negedge clk);
    check(rxOverrun && rxFull, "R7 overrun on full queue", {rxOverrun, rxFull}, 2'b11);
    monOn = 1'b1;
    drain();
    check(!rxReady && expQ.size() == 0, "R7 fourth char discarded", rxReady, 0);
    check(rxOverrun, "R7 overrun sticky", rxOverrun, 1);
    ovrClr = 1'b1; @(negedge clk); ovrClr = 1'b0; @(negedge clk);
    check(!rxOverrun, "R7 overrun cleared", rxOverrun, 0);

    // R3 stop length and back-to-back spacing: normal mode, 0xFF frames
    cfgMode = 2'd0; cfgStop = 4'd8;
    begin
      int cyc = 0;
      txWrite(8'hFF, 1'b0);
      txWrite(8'hFF, 1'b0);
      while (!txReady) @(negedge clk);
      check(txd == 1'b0, "R3 next start follows stop", txd, 0);
      txWrite(8'hFF, 1'b0);
      cyc = 1;
      while (!txReady) begin @(negedge clk); cyc++; end
      check(cyc == 336, "R3 frame spacing 168 ticks", cyc, 336);
      while (!txEmpty) @(negedge clk);
    end
    cfgStop = 4'd0;

    // R9 framing error, then R4 recovery
    expQ.push_back({1'b1, 1'b0, 8'h96});
    ser16({1'b0, 8'h96}, 1'b0, 1'b0);
    drain();
    check(expQ.size() == 0, "R9 framing-error char delivered", expQ.size(), 0);

    // R4 false start: short low pulse stores nothing
    rxd = 1'b0; waitTicks(4); rxd = 1'b1; waitTicks(40);
    check(!rxReady, "R4 short low pulse rejected", rxReady, 0);
    expQ.push_back({2'b00, 8'h6B});
    ser16({1'b0, 8'h6B}, 1'b0, 1'b1);
    drain();
    check(expQ.size() == 0, "R4 valid char after glitch", expQ.size(), 0);

    // R10 echo: line reflected and still received
    cfgMode = 2'd1;
    @(negedge clk); rxd = 1'b0; #1;
    check(txd == 1'b0, "R10 echo follows low", txd, 0);
    @(negedge clk); rxd = 1'b1; #1;
    check(txd == 1'b1, "R10 echo follows high", txd, 1);
    expQ.push_back({2'b00, 8'hE1});
    ser16({1'b0, 8'hE1}, 1'b0, 1'b1);
    drain();
    check(expQ.size() == 0, "R10 echo still receives", expQ.size(), 0);

    // R10 remote loop: reflected, nothing to the host
    cfgMode = 2'd3;
    @(negedge clk); rxd = 1'b0; #1;
    check(txd == 1'b0, "R10 remote follows low", txd, 0);
    ser16({1'b0, 8'h5A}, 1'b0, 1'b1);
    waitTicks(20);
    check(!rxReady, "R10 remote delivers nothing", rxReady, 0);

    // R8 completion and read in the same cycle, 1x with manual ticks
    cfgMode = 2'd0; cfgClk16 = 1'b0; monOn = 1'b0;
    @(negedge clk); tickAuto = 1'b0;
    ser1x(8'hA1, 1'b0);
    ser1x(8'hB2, 1'b0);
    ser1x(8'hC3, 1'b0);
    check(rxFull && rxRdData == 8'hA1, "R5 1x queue filled", {rxFull, rxRdData}, {1'b1, 8'hA1});
    ser1x(8'hD4, 1'b1);
    check(!rxOverrun && rxFull, "R8 read and completion together",
          {rxOverrun, rxFull}, 2'b01);
    expQ.push_back({2'b00, 8'hB2});
    expQ.push_back({2'b00, 8'hC3});
    expQ.push_back({2'b00, 8'hD4});
    monOn = 1'b1;
    drain();
    check(expQ.size() == 0 && !rxReady, "R8 order kept after collision", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule